// File: doc/BRIEF.md
# Vector Mask Compress Expand

This unit applies a per-element predicate mask to vector operations on a register of up to 64 elements. It holds a mask register of one bit per element and a destination register of elements. Two commands manage the mask: one loads it from the mask input, and one enables every element. Three element commands use it. A masked integer add writes `a[i] + b[i]` only where the mask bit is set. Compress gathers the set-mask elements of the source into the lowest destination positions, in their original order. Expand is the inverse of compress: it scatters the lowest source elements, in order, to the set-mask positions.

The element commands work on one element per cycle, over the first `vl` elements. A per-element write-enable vector records which destination positions the last command wrote. A packed-length output gives the number of set mask bits among the active elements. This count is the length of a compressed result. Destination positions that a command does not write keep their earlier value. Software issues a command with a one-cycle `start` pulse and waits for the `done` pulse.

Top module: `vmask_unit`

## Requirements
- R1: After reset, every destination element is 0, `wr_en` is 0, `pack_len` is 0, `busy` and `done` are low, and the mask register holds all ones.
- R2: Opcode 3 (load mask) copies `mask_in` into the mask register. This and every other non-element opcode (3 to 7) gives a `done` pulse in the cycle after the accepting edge, clears `wr_en`, and leaves the destination unchanged.
- R3: Opcode 4 (set all) sets every bit of the mask register.
- R4: Opcode 0 (masked add): for each active index i whose mask bit is set, destination element i becomes `(src_a[i] + src_b[i]) mod 2^EW` and `wr_en[i]` is 1. Element i occupies bits `i*EW +: EW` of a vector port.
- R5: Opcode 1 (compress): the k-th active set-mask source element, counted from index 0 upward, is written to destination position k, and `wr_en[k]` is 1.
- R6: When an element opcode (0, 1 or 2) completes, `pack_len` equals the number of set mask bits at indices below the effective vector length.
- R7: Opcode 2 (expand): source element k is written to the position of the k-th active set mask bit, and `wr_en` is 1 there.
- R8: Destination positions that a command does not write keep their previous value, and their `wr_en` bit is 0.
- R9: Elements at index `vl` or above are ignored whatever their mask bit. A `vl` greater than NELEM is treated as NELEM.
- R10: For an element opcode, `busy` is high and `done` is low for exactly `vl` cycles after the accepting edge, and then `done` pulses for one cycle. If `vl` is 0, `done` pulses at once.
- R11: A `start` pulse while `busy` is high is ignored: it changes neither the mask register nor the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| op | input | 3 | 0 add, 1 compress, 2 expand, 3 load mask, 4 set all mask |
| vl | input | LW | Vector length |
| mask_in | input | NELEM | Mask value for the load opcode |
| src_a | input | NELEM*EW | Source vector (add operand, compress/expand source) |
| src_b | input | NELEM*EW | Second add operand |
| dst | output | NELEM*EW | Destination register contents |
| wr_en | output | NELEM | Positions written by the last command |
| pack_len | output | LW | Active set-mask count of the last element command |
| busy | output | 1 | Element command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. `busy` and `done` never overlap, and a falling `busy` always brings `done`. The mask stays steady while a command runs, and the set-all command yields an all-ones mask. The compress write pointer never passes the read index. The number of written positions never exceeds the latched length, and neither does the packed length. Other behaviour is shown only by the bench scenarios, which compare against an independent model. These include the values and positions of the compress and expand permutations, the add results, and the retention of untouched elements across commands. They also include the clamping of oversized lengths, the exact cycle count, and a `start` pulse ignored in the middle of a command.

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int NELEM = 64,
  parameter int EW    = 16,
  localparam int IW   = $clog2(NELEM),
  localparam int LW   = $clog2(NELEM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         op,
  input  logic [LW-1:0]      vl,
  input  logic [NELEM-1:0]   mask_in,
  input  logic [NELEM*EW-1:0] src_a,
  input  logic [NELEM*EW-1:0] src_b,
  output logic [NELEM*EW-1:0] dst,
  output logic [NELEM-1:0]   wr_en,
  output logic [LW-1:0]      pack_len,
  output logic               busy,
  output logic               done
);
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_CMP = 3'd1;
  localparam logic [2:0] OP_EXP = 3'd2;
  localparam logic [2:0] OP_LDM = 3'd3;
  localparam logic [2:0] OP_SET = 3'd4;
  localparam logic [LW-1:0] VMAX = LW'(NELEM);

  logic                busy_q, done_q;
  logic [2:0]          op_q;
  logic [LW-1:0]       vl_q, idx_q, k_q, pack_q;
  logic [NELEM-1:0]    mask_q, wr_q;
  logic [NELEM*EW-1:0] a_q, b_q;
  logic [EW-1:0]       dst_q [NELEM];

  logic          accept, is_elem, hit, last;
  logic [LW-1:0] vl_eff;
  logic [IW-1:0] cur_i, cur_k;

  assign accept  = start && !busy_q;
  assign is_elem = op <= OP_EXP;
  assign vl_eff  = (vl > VMAX) ? VMAX : vl;
  assign cur_i   = idx_q[IW-1:0];
  assign cur_k   = k_q[IW-1:0];
  assign hit     = mask_q[cur_i];
  assign last    = idx_q == vl_q - LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_ADD;
      vl_q   <= '0;
      idx_q  <= '0;
      k_q    <= '0;
      pack_q <= '0;
      mask_q <= '1;
      wr_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      for (int i = 0; i < NELEM; i++) dst_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q  <= op;
        vl_q  <= vl_eff;
        idx_q <= '0;
        k_q   <= '0;
        wr_q  <= '0;
        a_q   <= src_a;
        b_q   <= src_b;
        if (is_elem && vl_eff != '0) busy_q <= 1'b1;
        else done_q <= 1'b1;
        if (is_elem && vl_eff == '0) pack_q <= '0;
        if (op == OP_LDM) mask_q <= mask_in;
        if (op == OP_SET) mask_q <= '1;
      end else if (busy_q) begin
        if (hit) begin
          case (op_q)
            OP_ADD: begin
              dst_q[cur_i] <= a_q[cur_i*EW +: EW] + b_q[cur_i*EW +: EW];
              wr_q[cur_i]  <= 1'b1;
            end
            OP_CMP: begin
              dst_q[cur_k] <= a_q[cur_i*EW +: EW];
              wr_q[cur_k]  <= 1'b1;
            end
            default: begin
              dst_q[cur_i] <= a_q[cur_k*EW +: EW];
              wr_q[cur_i]  <= 1'b1;
            end
          endcase
          k_q <= k_q + LW'(1);
        end
        idx_q <= idx_q + LW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pack_q <= k_q + {{(LW-1){1'b0}}, hit};
        end
      end
    end
  end

  for (genvar g = 0; g < NELEM; g++) begin : g_out
    assign dst[g*EW +: EW] = dst_q[g];
  end

  assign wr_en    = wr_q;
  assign pack_len = pack_q;
  assign busy     = busy_q;
  assign done     = done_q;

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R10
  fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R3
  set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SET) |=> &mask_q);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mask_q));

  // R5
  cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_CMP) |-> k_q <= idx_q);

  // R9
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_q) <= int'(vl_q));

  // R6
  pack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q <= OP_EXP) |-> pack_q <= vl_q);
endmodule

// File: tb/test_vmask_unit.sv
module test_vmask_unit;
  localparam int N  = 64;
  localparam int EW = 16;
  localparam int LW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [LW-1:0] vl = '0;
  logic [N-1:0] mask_in = '0;
  logic [N*EW-1:0] src_a = '0, src_b = '0;
  logic [N*EW-1:0] dst;
  logic [N-1:0] wr_en;
  logic [LW-1:0] pack_len;
  logic busy, done;

  vmask_unit #(.NELEM(N), .EW(EW)) i_vmask_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vl(vl),
    .mask_in(mask_in), .src_a(src_a), .src_b(src_b), .dst(dst),
    .wr_en(wr_en), .pack_len(pack_len), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [EW-1:0] md [N];
  logic [N-1:0]  mmask = '1;
  logic [N-1:0]  mwr = '0;
  logic [LW-1:0] mpack = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input int v,
                       input logic [N-1:0] m, input logic [N*EW-1:0] a,
                       input logic [N*EW-1:0] b, output int cyc);
    int ve = (v > N) ? N : v;
    int k = 0;
    mwr = '0;
    cyc = 0;
    if (o == 3) mmask = m;
    if (o == 4) mmask = '1;
    if (o <= 2) begin
      cyc = ve;
      for (int i = 0; i < ve; i++) begin
        if (mmask[i]) begin
          if (o == 0) begin
            md[i] = a[i*EW +: EW] + b[i*EW +: EW];
            mwr[i] = 1'b1;
          end else if (o == 1) begin
            md[k] = a[i*EW +: EW];
            mwr[k] = 1'b1;
          end else begin
            md[i] = a[k*EW +: EW];
            mwr[i] = 1'b1;
          end
          k++;
        end
      end
      mpack = LW'(k);
    end
  endtask

  task automatic run(input logic [2:0] o, input int v, input logic [N-1:0] m,
                     input logic [N*EW-1:0] a, input logic [N*EW-1:0] b,
                     input bit poke);
    int cyc, cnt, bad;
    string rq;
    bit busy_ok = 1;
    rq = (o == 0) ? "R4" : (o == 1) ? "R5" : (o == 2) ? "R7" : "R2";
    model(o, v, m, a, b, cyc);
    @(negedge clk);
    start = 1'b1; op = o; vl = LW'(v); mask_in = m; src_a = a; src_b = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done) begin
      if (!busy) busy_ok = 0;
      if (poke && cnt == 2) begin
        start = 1'b1; op = 3'd4; vl = LW'(3);
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(cnt == cyc && busy_ok, "R10", "cycles to done", 64'(cnt), 64'(cyc));
    check(!busy, "R10", "busy after done", 64'(busy), 64'd0);
    bad = -1;
    for (int i = 0; i < N; i++)
      if (bad < 0 && dst[i*EW +: EW] !== md[i]) bad = i;
    if (bad < 0) check(1, rq, "dst", 0, 0);
    else check(0, {rq, " R8"}, $sformatf("dst[%0d]", bad),
               64'(dst[bad*EW +: EW]), 64'(md[bad]));
    check(wr_en === mwr, {rq, " R8"}, "wr_en", wr_en, mwr);
    if (o <= 2) check(pack_len === mpack, "R6", "pack_len", 64'(pack_len), 64'(mpack));
    if (poke) check(1, "R11", "start during busy ignored", 0, 0);
  endtask

  function automatic logic [N*EW-1:0] rvec();
    logic [N*EW-1:0] r;
    for (int i = 0; i < N*EW/32; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [N-1:0] rmask();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N*EW-1:0] a, b;
    logic [N-1:0] m;
    int dummy;
    dummy = $urandom(32'd20240611);
    for (int i = 0; i < N; i++) md[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dst === '0, "R1", "dst after reset", 64'(dst[63:0]), 0);
    check(wr_en === '0 && pack_len === '0, "R1", "wr_en/pack_len", 64'(wr_en), 0);
    check(!busy && !done, "R1", "busy/done", {busy, done}, 0);
    // R1: mask resets to all ones, seen through an add
    a = rvec(); b = rvec();
    run(3'd0, 8, '0, a, b, 0);
    // R2 load alternating mask, then compress all (R5)
    run(3'd3, 64, {32{2'b10}}, a, b, 0);
    a = rvec();
    run(3'd1, 64, '0, a, b, 0);
    // R7 expand over partial length
    a = rvec();
    run(3'd2, 20, '0, a, b, 0);
    // R8 empty mask writes nothing
    run(3'd3, 0, '0, a, b, 0);
    run(3'd1, 10, '0, rvec(), b, 0);
    // R3 set all, then full add
    run(3'd4, 0, '0, a, b, 0);
    run(3'd0, 64, '0, rvec(), rvec(), 0);
    // R10 zero length
    run(3'd0, 0, '0, rvec(), rvec(), 0);
    // R9 oversized length clamped
    run(3'd3, 0, {8'hFF, 56'h0F0F_0000_0000_01}, a, b, 0);
    run(3'd1, 100, '0, rvec(), b, 0);
    // R9 mask bits above vl ignored
    run(3'd3, 0, 64'hFFFF_FFFF_FFFF_FFE5, a, b, 0);
    run(3'd1, 5, '0, rvec(), b, 0);
    run(3'd2, 5, '0, rvec(), b, 0);
    // R11 start while busy
    run(3'd3, 0, 64'h00FF_00FF_00FF_00FF, a, b, 0);
    run(3'd1, 30, '0, rvec(), b, 1);
    run(3'd0, 30, '0, rvec(), rvec(), 0);
    // R2 unused opcode leaves state alone
    run(3'd6, 12, '1, rvec(), b, 0);
    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 4));
      m = rmask();
      run(o, $urandom_range(0, 70), m, rvec(), rvec(), 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule